// File: doc/BRIEF.md
# Strided Block Copy Engine

This engine performs one memory-to-memory copy described by a loaded set of control values: a transfer-option word, a source address, a destination address, a length word and a stride word. It moves the data in 32-bit beats over a simple master port. For each beat it reads one word and then writes that word, and it never has more than one beat in flight. The same port also reports the live source address, destination address and remaining length after every beat, so a surrounding controller can watch the copy as it progresses.

In linear mode the whole length forms a single row. In two-dimensional mode the length word holds both a row count and a per-row byte count. After every row except the last, signed 16-bit strides are added to both addresses. Two option bits control the data path. One suppresses source reads so that the engine writes zeros, which gives a memory fill. The other suppresses destination writes, which gives a dummy read pass. In both cases the beat still counts toward the length.

Top module: `strided_copy_engine`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `rd_req` and `wr_req` are all low.
- R2: When `start` is high and the engine is idle, it loads the configuration and runs ceil(row bytes / 4) beats per row. Each beat reads at the live source address and then writes the returned word to the live destination address. A row whose byte count is not a multiple of 4 is rounded up to whole beats.
- R3: If option bit 8 is set, the source address advances by 4 after each beat. If option bit 4 is set, the destination address advances by 4 after each beat. If a bit is clear, that address holds its value.
- R4: Option bit 1 selects two-dimensional mode. In this mode the row count is length[29:16] + 1 and the row byte count is length[15:0]. After each row except the last, the sign-extended value stride[15:0] is added to the source address and the sign-extended value stride[31:16] is added to the destination address. In linear mode there is one row, its byte count is the full length word, and no stride is added.
- R5: If option bit 11 is set, no read request is issued and every beat writes the value 0.
- R6: If option bit 7 is set, no write request is issued. The beat still advances the addresses and the remaining length.
- R7: At start, `live_len` takes the length word. After every beat it shows the bytes remaining in the current row. In two-dimensional mode, bits [30:16] also hold the number of rows remaining, counting the current row.
- R8: A row with a byte count of 0 completes in one cycle without any memory access. A linear transfer of length 0 finishes without any access.
- R9: Once raised, `rd_req` and its address stay steady until `rd_valid` is seen. Once raised, `wr_req` and its address and data stay steady until `wr_ack` is seen. Read and write requests are never high together.
- R10: `done` pulses for exactly one cycle, in the same cycle that `busy` drops. A `start` that arrives while `busy` is high has no effect, and neither does a change to the configuration inputs during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transfer (sampled when idle) |
| cfg_info | input | 12 | Transfer option bits |
| cfg_src | input | 32 | Initial source address |
| cfg_dst | input | 32 | Initial destination address |
| cfg_len | input | 32 | Length word |
| cfg_stride | input | 32 | Stride word, destination stride in the upper half, source stride in the lower half |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_valid | input | 1 | Read data valid, completes the read |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| live_src | output | 32 | Live source address |
| live_dst | output | 32 | Live destination address |
| live_len | output | 32 | Live remaining length |

## Verification
A new `start` can arrive, with changed configuration inputs, in the same cycle that a beat is completing its read or write handshake. If the engine wrongly accepted that start, it would corrupt the beat in progress. The bench provokes this case by raising `start` a cycle after launch, with the source address scrambled, while the memory response delay varies from zero to two cycles. This places the second start on the read-wait, read-accept and write-accept cycles. The case is judged by comparing the write address and data sequence, the final live addresses and the final length against values computed from the original configuration only.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROW   = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } sce_state_t;

  // option-word bit positions decoded by the engine
  localparam int OPT_TWO_D   = 1;
  localparam int OPT_DST_INC = 4;
  localparam int OPT_DST_IGN = 7;
  localparam int OPT_SRC_INC = 8;
  localparam int OPT_SRC_IGN = 11;
endpackage

// File: rtl/sce_beat_fsm.sv
module sce_beat_fsm
  import sce_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_ign,
  input  logic              dst_ign,
  input  logic              row_empty,
  input  logic              last_row,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ack,
  output logic              load,
  output logic              beat_done,
  output logic              row_adv,
  output logic              busy,
  output logic              done,
  output logic              rd_req,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data
);
  sce_state_t        st_q, st_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              finish;
  logic              done_q;

  always_comb begin
    st_d      = st_q;
    data_d    = data_q;
    data_en   = 1'b0;
    load      = 1'b0;
    beat_done = 1'b0;
    row_adv   = 1'b0;
    finish    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          st_d = ST_ROW;
        end
      end
      ST_ROW: begin
        if (row_empty) begin
          if (last_row) begin
            finish = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            row_adv = 1'b1;
          end
        end else if (src_ign) begin
          data_d  = '0;
          data_en = 1'b1;
          st_d    = ST_WRITE;
        end else begin
          st_d = ST_READ;
        end
      end
      ST_READ: begin
        if (rd_valid) begin
          data_d  = rd_data;
          data_en = 1'b1;
          st_d    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (dst_ign || wr_ack) begin
          beat_done = 1'b1;
          st_d      = ST_ROW;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (data_en) data_q <= data_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign rd_req  = (st_q == ST_READ);
  assign wr_req  = (st_q == ST_WRITE) && !dst_ign;
  assign wr_data = data_q;
endmodule

// File: rtl/sce_len_track.sv
module sce_len_track #(
  parameter int LEN_W  = 32,
  parameter int XLEN_W = 16,
  parameter int ROWS_W = 14,
  parameter int BEAT_B = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cfg_2d,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             beat_done,
  input  logic             row_adv,
  output logic             row_empty,
  output logic             last_row,
  output logic [LEN_W-1:0] live_len
);
  localparam int ROWC_W = ROWS_W + 1;
  localparam int PAD_W  = LEN_W - XLEN_W - ROWC_W;

  logic             mode_q, mode_d;
  logic [LEN_W-1:0] rb_q, rb_d, xrem_q, xrem_d, live_q, live_d, xrem_dec;
  logic [ROWC_W-1:0] rows_q, rows_d;
  logic [LEN_W-1:0] init_rb;
  logic [ROWC_W-1:0] init_rows;

  always_comb begin
    init_rb   = cfg_2d ? LEN_W'(cfg_len[XLEN_W-1:0]) : cfg_len;
    init_rows = cfg_2d ? ROWC_W'(cfg_len[XLEN_W +: ROWS_W]) + ROWC_W'(1) : ROWC_W'(1);
    xrem_dec  = (xrem_q < LEN_W'(BEAT_B)) ? '0 : xrem_q - LEN_W'(BEAT_B);
    mode_d = mode_q;
    rb_d   = rb_q;
    xrem_d = xrem_q;
    rows_d = rows_q;
    live_d = live_q;
    if (load) begin
      mode_d = cfg_2d;
      rb_d   = init_rb;
      xrem_d = init_rb;
      rows_d = init_rows;
      live_d = cfg_len;
    end else if (beat_done) begin
      xrem_d = xrem_dec;
      live_d = mode_q ? {{PAD_W{1'b0}}, rows_q, xrem_dec[XLEN_W-1:0]} : xrem_dec;
    end else if (row_adv) begin
      rows_d = rows_q - ROWC_W'(1);
      xrem_d = rb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rb_q   <= '0;
      xrem_q <= '0;
      rows_q <= '0;
      live_q <= '0;
    end else begin
      mode_q <= mode_d;
      rb_q   <= rb_d;
      xrem_q <= xrem_d;
      rows_q <= rows_d;
      live_q <= live_d;
    end
  end

  assign row_empty = (xrem_q == '0);
  assign last_row  = (rows_q == ROWC_W'(1));
  assign live_len  = live_q;
endmodule

// File: rtl/sce_addr_unit.sv
module sce_addr_unit #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int BEAT_B   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   init_addr,
  input  logic [STRIDE_W-1:0] init_stride,
  input  logic                step_en,
  input  logic                row_adv,
  output logic [ADDR_W-1:0]   addr
);
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [STRIDE_W-1:0] str_q, str_d;

  always_comb begin
    addr_d = addr_q;
    str_d  = str_q;
    if (load) begin
      addr_d = init_addr;
      str_d  = init_stride;
    end else if (step_en) begin
      addr_d = addr_q + ADDR_W'(BEAT_B);
    end else if (row_adv) begin
      addr_d = addr_q + {{(ADDR_W-STRIDE_W){str_q[STRIDE_W-1]}}, str_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      str_q  <= '0;
    end else begin
      addr_q <= addr_d;
      str_q  <= str_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/strided_copy_engine.sv
module strided_copy_engine
  import sce_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 32,
  parameter int OPT_W    = 12,
  parameter int XLEN_W   = 16,
  parameter int ROWS_W   = 14,
  parameter int STRIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPT_W-1:0]  cfg_info,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [2*STRIDE_W-1:0] cfg_stride,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] live_src,
  output logic [ADDR_W-1:0] live_dst,
  output logic [LEN_W-1:0]  live_len
);
  localparam int BEAT_B = DATA_W / 8;
  localparam int N_PTR  = 2; // 0: source, 1: destination

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [OPT_W-1:0] opt_q;
  logic             load, beat_done, row_adv, row_empty, last_row;
  logic [ADDR_W-1:0]   ptr_init [N_PTR];
  logic [STRIDE_W-1:0] ptr_str  [N_PTR];
  logic                ptr_inc  [N_PTR];
  logic [ADDR_W-1:0]   ptr_addr [N_PTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  opt_q <= '0;
    else if (load)    opt_q <= cfg_info;
  end

  assign ptr_init[0] = cfg_src;
  assign ptr_init[1] = cfg_dst;
  assign ptr_str[0]  = cfg_info[OPT_TWO_D] ? cfg_stride[STRIDE_W-1:0] : '0;
  assign ptr_str[1]  = cfg_info[OPT_TWO_D] ? cfg_stride[2*STRIDE_W-1:STRIDE_W] : '0;
  assign ptr_inc[0]  = opt_q[OPT_SRC_INC];
  assign ptr_inc[1]  = opt_q[OPT_DST_INC];

  sce_beat_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .start(start),
    .src_ign(opt_q[OPT_SRC_IGN]), .dst_ign(opt_q[OPT_DST_IGN]),
    .row_empty(row_empty), .last_row(last_row),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack),
    .load(load), .beat_done(beat_done), .row_adv(row_adv),
    .busy(busy), .done(done), .rd_req(rd_req), .wr_req(wr_req),
    .wr_data(wr_data)
  );

  sce_len_track #(.LEN_W(LEN_W), .XLEN_W(XLEN_W), .ROWS_W(ROWS_W), .BEAT_B(BEAT_B)) u_len (
    .clk(clk), .rst_n(rst_core_n), .load(load), .cfg_2d(cfg_info[OPT_TWO_D]),
    .cfg_len(cfg_len), .beat_done(beat_done), .row_adv(row_adv),
    .row_empty(row_empty), .last_row(last_row), .live_len(live_len)
  );

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    sce_addr_unit #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .BEAT_B(BEAT_B)) u_addr (
      .clk(clk), .rst_n(rst_core_n), .load(load),
      .init_addr(ptr_init[g]), .init_stride(ptr_str[g]),
      .step_en(beat_done && ptr_inc[g]), .row_adv(row_adv),
      .addr(ptr_addr[g])
    );
  end

  assign live_src = ptr_addr[0];
  assign live_dst = ptr_addr[1];
  assign rd_addr  = ptr_addr[0];
  assign wr_addr  = ptr_addr[1];
endmodule

// File: rtl/sce_checker.sv
module sce_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ack,
  input logic [LEN_W-1:0]  live_len
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack) |=> (live_len != $past(live_len)));
endmodule

bind strided_copy_engine sce_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_sce_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
  .live_len(live_len)
);

// File: tb/strided_copy_engine_tb_top.sv
module strided_copy_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] cfg_info;
  logic [31:0] cfg_src, cfg_dst, cfg_len, cfg_stride;
  logic        rd_req, rd_valid, wr_req, wr_ack, busy, done;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, live_src, live_dst, live_len;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  localparam logic [31:0] SRC0 = 32'h0000_1000;
  localparam logic [31:0] DST0 = 32'h0000_8000;

  always #10 clk = ~clk;

  strided_copy_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_info(cfg_info),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_stride(cfg_stride),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .live_src(live_src), .live_dst(live_dst),
    .live_len(live_len)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [11:0] info, input logic [31:0] len,
                          input logic [31:0] stride, input int lat);
    logic [31:0] exp_ra [32];
    logic [31:0] exp_wa [32];
    logic [31:0] exp_wd [32];
    logic [31:0] exp_lb [32];
    int nr = 0, nw = 0, nbeats = 0, ri = 0, wi = 0, wait_n = 0, rows, rb, bpr;
    bit two_d, sign, dign, sinc, dinc, fin = 0;
    logic [31:0] s, d, ss, ds, cur, xr;
    two_d = info[1]; dinc = info[4]; dign = info[7]; sinc = info[8]; sign = info[11];
    rows = two_d ? int'(len[29:16]) + 1 : 1;
    rb   = two_d ? int'(len[15:0]) : int'(len);
    bpr  = (rb + 3) / 4;
    ss = two_d ? {{16{stride[15]}}, stride[15:0]} : 32'd0;
    ds = two_d ? {{16{stride[31]}}, stride[31:16]} : 32'd0;
    s = SRC0; d = DST0; cur = len;
    for (int r = 0; r < rows; r++) begin
      for (int b = 0; b < bpr; b++) begin
        if (!sign) begin exp_ra[nr] = s; nr++; end
        if (!dign) begin
          exp_wa[nw] = d; exp_wd[nw] = sign ? 32'd0 : pat(s); exp_lb[nw] = cur; nw++;
        end
        if (sinc) s = s + 32'd4;
        if (dinc) d = d + 32'd4;
        xr = (rb - 4 * (b + 1) < 0) ? 32'd0 : 32'(rb - 4 * (b + 1));
        cur = two_d ? {16'(rows - r), xr[15:0]} : xr;
        nbeats++;
      end
      if (r < rows - 1) begin s = s + ss; d = d + ds; end
    end

    @(negedge clk);
    cfg_info = info; cfg_src = SRC0; cfg_dst = DST0; cfg_len = len; cfg_stride = stride;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      // R10: second start with scrambled configuration while busy
      if (nbeats >= 2 && cyc == 1) begin start = 1'b1; cfg_src = ~SRC0; cfg_len = 32'h0000_0100; end
      if (cyc == 2) begin start = 1'b0; cfg_src = SRC0; cfg_len = len; end
      if (rd_req && wr_req) chk(0, "R9 read and write together", 32'd1, 32'd0);
      if (done) begin
        fin = 1;
        chk(busy == 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
        chk(live_src == s, "R3/R4 final source address", live_src, s);
        chk(live_dst == d, "R3/R4 final destination address", live_dst, d);
        chk(live_len == cur, "R7 final length", live_len, cur);
        chk(ri == nr, "R5 read count", 32'(ri), 32'(nr));
        chk(wi == nw, "R6 write count", 32'(wi), 32'(nw));
      end
      rd_valid = 1'b0; wr_ack = 1'b0;
      if (rd_req) begin
        if (wait_n >= lat) begin
          if (ri < nr) chk(rd_addr == exp_ra[ri], "R2 read address", rd_addr, exp_ra[ri]);
          else         chk(0, "R5 unexpected read", rd_addr, 32'd0);
          rd_valid = 1'b1; rd_data = pat(rd_addr); ri++; wait_n = 0;
        end else wait_n++;
      end else if (wr_req) begin
        if (wait_n >= lat) begin
          if (wi < nw) begin
            chk(wr_addr == exp_wa[wi], "R2 write address", wr_addr, exp_wa[wi]);
            chk(wr_data == exp_wd[wi], "R2 write data", wr_data, exp_wd[wi]);
            chk(live_len == exp_lb[wi], "R7 live length before beat", live_len, exp_lb[wi]);
          end else chk(0, "R6 unexpected write", wr_addr, 32'd0);
          wr_ack = 1'b1; wi++; wait_n = 0;
        end else wait_n++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(fin, "R8 transfer completes", 32'(fin), 32'd1);
    chk(done == 1'b0, "R10 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    for (int w = 0; w < 200000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lens [9];
    logic [31:0] strs [9];
    int idx = 0;
    rst_n = 1'b0; start = 1'b0; cfg_info = '0; cfg_src = '0; cfg_dst = '0;
    cfg_len = '0; cfg_stride = '0; rd_valid = 1'b0; rd_data = '0; wr_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, rd_req, wr_req} == 4'b0, "R1 outputs in reset", 32'({busy, done, rd_req, wr_req}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, rd_req, wr_req} == 4'b0, "R1 outputs after reset", 32'({busy, done, rd_req, wr_req}), 32'd0);

    // linear lengths (R2, R8 rounding and zero), then 2D (R4, R8 zero rows)
    lens[0] = 32'd0;  strs[0] = 32'h0;
    lens[1] = 32'd1;  strs[1] = 32'h0;
    lens[2] = 32'd4;  strs[2] = 32'h0;
    lens[3] = 32'd7;  strs[3] = 32'h0;
    lens[4] = 32'd12; strs[4] = 32'h1234_5678;
    lens[5] = {2'b0, 14'd0, 16'd8};  strs[5] = {16'hFFFC, 16'd16};
    lens[6] = {2'b0, 14'd2, 16'd6};  strs[6] = {16'd12, 16'hFFE0};
    lens[7] = {2'b0, 14'd1, 16'd0};  strs[7] = {16'd8, 16'd8};
    lens[8] = {2'b0, 14'd3, 16'd4};  strs[8] = {16'd100, 16'hFFF8};
    for (int c = 0; c < 9; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [11:0] info;
        info = '0;
        info[1]  = (c >= 5);
        info[8]  = f[0];  // R3 source increment
        info[4]  = f[1];  // R3 destination increment
        info[11] = f[2];  // R5 source ignore
        info[7]  = f[3];  // R6 destination ignore
        run_case(info, lens[c], strs[c], idx % 3);
        idx++;
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule